// File: doc/BRIEF.md
# DMA Bus Tenure Controller

This block decides how long a bus-mastering DMA engine holds the system bus after it has been granted. It keeps two programmable limits: a cap on clock cycles of tenure, and a cap on transfers per tenure. It also keeps the memory address pointer and the remaining-byte counter for the current buffer. It raises a release request when any one of three conditions holds: the cycle cap is reached while the timer is enabled, the transfer cap is reached, or no work is pending.

Host software programs the four registers through a simple select/write/read port. The port accepts access only while the engine is stopped or suspended. A test-enable input changes how the timer register responds to writes: each write steps the stored cap down by one instead of loading the written value, so the counting logic can be checked quickly. The bus protocol itself, descriptor handling and data movement are handled by surrounding logic.

Register select codes: 0 is the cycle cap, 1 is the transfer cap, 2 is the memory address and 3 is the byte counter. Caps and the address read back zero-extended.

Top module: `dma_tenure_ctrl`

## Requirements
- R1: Host writes change a register only while `halted` is 1; writes with `halted` at 0 are ignored, and reads with `halted` at 0 return zero.
- R2: With `timer_en` at 1 and a cycle cap of L, and no other release condition present, `release_req` is low after L rising edges of continuous grant and high after edge L+1.
- R3: With `timer_en` at 0, no length of grant causes release while work is pending and the transfer cap is not reached.
- R4: With a transfer cap of N, `release_req` rises on the edge after the N-th accepted transfer of the current tenure.
- R5: When `work_pending` is 0 during grant, `release_req` is high after the next rising edge.
- R6: Once raised, `release_req` stays high while `bus_grant` stays high, and is low after the first edge at which `bus_grant` is 0.
- R7: Every new grant restarts both the cycle count and the transfer count from zero.
- R8: While `test_en` is 1, a write to the cycle-cap register (select 0) lowers the stored cap by one and ignores the write data.
- R9: Each accepted transfer (`xfer_strobe` during grant while `buf_empty` is 0) adds one to `mem_addr`.
- R10: The byte counter holds the two's-complement of the remaining bytes and adds one per accepted transfer. Reads of select 3 return the counter in bits 11:0 with bits 15:12 all ones and the upper bits zero.
- R11: `buf_empty` is 1 exactly when the byte counter is zero. While it is 1, strobes leave the address and the counters unchanged.
- R12: After reset, `release_req` is 0, `mem_addr` is 0, the byte counter is 0 (so `buf_empty` is 1), and both caps hold all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_grant | input | 1 | Bus granted to the DMA engine |
| xfer_strobe | input | 1 | One transfer performed this cycle |
| work_pending | input | 1 | Engine still has work queued |
| timer_en | input | 1 | Enables the cycle-cap release condition |
| test_en | input | 1 | Timer-register writes decrement instead of load |
| halted | input | 1 | Engine stopped or suspended; gates host access |
| reg_wr | input | 1 | Host write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data for the selected register |
| release_req | output | 1 | Request to give up the bus |
| mem_addr | output | 32 | Current memory address |
| buf_empty | output | 1 | Byte counter has reached zero |

## Verification
The bench checks the timer release on its exact edge. If the counter starts from one, or the comparison uses strictly greater than, the request appears a cycle early or late. It ends a tenure and opens a new one to catch counters that are not cleared between grants. A faulty design would then release at once with no strobes. It runs the byte counter through its wrap to zero and sends one more strobe; a design that does not block transfers on an empty buffer moves the address one step too far. It writes while running and in test mode to expose a design that loads instead of ignoring, or loads instead of decrementing.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
   typedef enum logic [1:0] {
      SEL_TIMER = 2'd0,
      SEL_BURST = 2'd1,
      SEL_ADDR  = 2'd2,
      SEL_BCNT  = 2'd3
   } dtc_sel_e;

   localparam int unsigned BC_PAD_W = 4;
endpackage

// File: rtl/dtc_limit_counter.sv
module dtc_limit_counter #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   input  logic [W-1:0] limit,
   output logic         hit
);
   logic [W-1:0] cnt_q;

   assign hit = (cnt_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (clr)          cnt_q <= '0;
      else if (inc && !hit)  cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/dtc_addr_unit.sv
module dtc_addr_unit #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned BC_W   = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_addr,
   input  logic              ld_bc,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [BC_W-1:0]   bc_in,
   input  logic              step,
   output logic [ADDR_W-1:0] addr,
   output logic [BC_W-1:0]   bc,
   output logic              empty
);
   assign empty = (bc == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             addr <= '0;
      else if (ld_addr)       addr <= addr_in;
      else if (step && !empty) addr <= addr + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             bc <= '0;
      else if (ld_bc)         bc <= bc_in;
      else if (step && !empty) bc <= bc + 1'b1;
   end
endmodule

// File: rtl/dtc_release_ctl.sv
module dtc_release_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic grant,
   input  logic tmr_hit,
   input  logic xfer_hit,
   input  logic idle,
   output logic rel
);
   logic cause;

   assign cause = tmr_hit | xfer_hit | idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rel <= 1'b0;
      else if (!grant) rel <= 1'b0;
      else             rel <= rel | cause;
   end
endmodule

// File: rtl/dma_tenure_ctrl.sv
module dma_tenure_ctrl
   import dtc_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned TMR_W     = 16,
   parameter int unsigned BURST_W   = 8,
   parameter int unsigned BC_W      = 12,
   parameter bit          HAS_TIMER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_grant,
   input  logic              xfer_strobe,
   input  logic              work_pending,
   input  logic              timer_en,
   input  logic              test_en,
   input  logic              halted,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              release_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              buf_empty
);
   localparam int unsigned BC_RD_W = BC_W + BC_PAD_W;

   if (TMR_W > DATA_W || BURST_W > DATA_W || ADDR_W > DATA_W) begin : g_bad_width
      $error("dma_tenure_ctrl: register wider than data port");
   end
   if (BC_RD_W > DATA_W) begin : g_bad_bc
      $error("dma_tenure_ctrl: byte counter and pad exceed data port");
   end
   if (TMR_W == 0 || BURST_W == 0 || BC_W == 0) begin : g_bad_zero
      $error("dma_tenure_ctrl: zero-width field");
   end

   dtc_sel_e          sel;
   logic              wr_ok;
   logic [TMR_W-1:0]  tmr_lim_q;
   logic [BURST_W-1:0] burst_lim_q;
   logic [BC_W-1:0]   bc;
   logic              step;
   logic              tmr_hit;
   logic              xfer_hit;

   assign sel   = dtc_sel_e'(reg_sel);
   assign wr_ok = reg_wr & halted;
   assign step  = bus_grant & xfer_strobe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_lim_q <= '1;
      end else if (wr_ok && sel == SEL_TIMER) begin
         if (test_en) tmr_lim_q <= tmr_lim_q - 1'b1;
         else         tmr_lim_q <= reg_wdata[TMR_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          burst_lim_q <= '1;
      else if (wr_ok && sel == SEL_BURST)  burst_lim_q <= reg_wdata[BURST_W-1:0];
   end

   if (HAS_TIMER) begin : g_timer
      logic tmr_raw;
      dtc_limit_counter #(.W(TMR_W)) i_tmr_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (!bus_grant),
         .inc   (1'b1),
         .limit (tmr_lim_q),
         .hit   (tmr_raw)
      );
      assign tmr_hit = tmr_raw & timer_en & bus_grant;
   end else begin : g_no_timer
      assign tmr_hit = 1'b0;
   end

   dtc_limit_counter #(.W(BURST_W)) i_xfer_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!bus_grant),
      .inc   (step & ~buf_empty),
      .limit (burst_lim_q),
      .hit   (xfer_hit)
   );

   dtc_addr_unit #(.ADDR_W(ADDR_W), .BC_W(BC_W)) i_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_addr (wr_ok && sel == SEL_ADDR),
      .ld_bc   (wr_ok && sel == SEL_BCNT),
      .addr_in (reg_wdata[ADDR_W-1:0]),
      .bc_in   (reg_wdata[BC_W-1:0]),
      .step    (step),
      .addr    (mem_addr),
      .bc      (bc),
      .empty   (buf_empty)
   );

   dtc_release_ctl i_rel (
      .clk      (clk),
      .rst_n    (rst_n),
      .grant    (bus_grant),
      .tmr_hit  (tmr_hit),
      .xfer_hit (xfer_hit),
      .idle     (~work_pending),
      .rel      (release_req)
   );

   always_comb begin
      reg_rdata = '0;
      if (halted) begin
         unique case (sel)
            SEL_TIMER: reg_rdata[TMR_W-1:0]   = tmr_lim_q;
            SEL_BURST: reg_rdata[BURST_W-1:0] = burst_lim_q;
            SEL_ADDR:  reg_rdata[ADDR_W-1:0]  = mem_addr;
            SEL_BCNT: begin
               reg_rdata[BC_RD_W-1:BC_W] = '1;
               reg_rdata[BC_W-1:0]       = bc;
            end
            default:   reg_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/dma_tenure_ctrl_chk.sv
module dma_tenure_ctrl_chk #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_grant,
   input logic              xfer_strobe,
   input logic              work_pending,
   input logic              halted,
   input logic              reg_wr,
   input logic              release_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              buf_empty
);
   AST_REL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (release_req && bus_grant) |=> release_req);                      // R6

   AST_REL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_grant |=> !release_req);                                     // R6

   AST_IDLE_REL: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_grant && !work_pending) |=> release_req);                    // R5

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_grant && xfer_strobe && !buf_empty && !(reg_wr && halted))
      |=> (mem_addr == $past(mem_addr) + 1'b1));                        // R9

   AST_EMPTY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_empty && !(reg_wr && halted)) |=> $stable(mem_addr));        // R11

   AST_RUN_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (!halted && !(bus_grant && xfer_strobe)) |=> $stable(mem_addr));  // R1
endmodule

bind dma_tenure_ctrl dma_tenure_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_grant    (bus_grant),
   .xfer_strobe  (xfer_strobe),
   .work_pending (work_pending),
   .halted       (halted),
   .reg_wr       (reg_wr),
   .release_req  (release_req),
   .mem_addr     (mem_addr),
   .buf_empty    (buf_empty)
);

// File: tb/test_dma_tenure_ctrl.sv
`timescale 1ns/1ps
module test_dma_tenure_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_grant = 1'b0, xfer_strobe = 1'b0, work_pending = 1'b1;
   logic        timer_en = 1'b0, test_en = 1'b0, halted = 1'b1, reg_wr = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        release_req;
   logic [31:0] mem_addr;
   logic        buf_empty;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;

   dma_tenure_ctrl i_dma_tenure_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_grant(bus_grant), .xfer_strobe(xfer_strobe),
      .work_pending(work_pending), .timer_en(timer_en), .test_en(test_en),
      .halted(halted), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .release_req(release_req), .mem_addr(mem_addr),
      .buf_empty(buf_empty)
   );

   task automatic tick(int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] s, logic [31:0] d);
      reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
      tick();
      reg_wr = 1'b0;
   endtask

   task automatic rd_chk(string req, logic [1:0] s, logic [31:0] exp);
      reg_sel = s;
      #1;
      chk(req, reg_rdata, exp);
   endtask

   task automatic end_grant();
      bus_grant = 1'b0; xfer_strobe = 1'b0; work_pending = 1'b1;
      tick();
   endtask

   task automatic t_reset();
      chk("R12 release", {31'd0, release_req}, 32'd0);
      chk("R12 addr", mem_addr, 32'd0);
      chk("R12 empty", {31'd0, buf_empty}, 32'd1);
      rd_chk("R12 timer cap", 2'd0, 32'h0000_FFFF);
      rd_chk("R12 burst cap", 2'd1, 32'h0000_00FF);
   endtask

   task automatic t_access();
      halted = 1'b0;
      wr(2'd2, 32'h0000_0100);
      rd_chk("R1 read gated", 2'd2, 32'd0);
      halted = 1'b1;
      rd_chk("R1 run write ignored", 2'd2, 32'd0);
      wr(2'd2, 32'h0000_1000);
      rd_chk("R1 halted write", 2'd2, 32'h0000_1000);
   endtask

   task automatic t_timer();
      wr(2'd0, 32'd5);
      wr(2'd1, 32'd200);
      wr(2'd3, 32'h0000_0FF0);
      halted = 1'b0; timer_en = 1'b1; work_pending = 1'b1;
      bus_grant = 1'b1;
      tick(5);
      chk("R2 not yet", {31'd0, release_req}, 32'd0);
      tick();
      chk("R2 timer release", {31'd0, release_req}, 32'd1);
      tick(3);
      chk("R6 held", {31'd0, release_req}, 32'd1);
      end_grant();
      chk("R6 cleared", {31'd0, release_req}, 32'd0);
   endtask

   task automatic t_notimer();
      timer_en = 1'b0; bus_grant = 1'b1;
      tick(20);
      chk("R3 no timer release", {31'd0, release_req}, 32'd0);
      end_grant();
   endtask

   task automatic t_burst();
      halted = 1'b1;
      wr(2'd1, 32'd4);
      halted = 1'b0;
      bus_grant = 1'b1; xfer_strobe = 1'b1;
      tick(4);
      xfer_strobe = 1'b0;
      chk("R4 not yet", {31'd0, release_req}, 32'd0);
      tick();
      chk("R4 burst release", {31'd0, release_req}, 32'd1);
      chk("R9 addr", mem_addr, 32'h0000_1004);
      end_grant();
      bus_grant = 1'b1;
      tick(2);
      chk("R7 restart", {31'd0, release_req}, 32'd0);
      end_grant();
   endtask

   task automatic t_idle();
      bus_grant = 1'b1; work_pending = 1'b0;
      tick();
      chk("R5 idle release", {31'd0, release_req}, 32'd1);
      end_grant();
   endtask

   task automatic t_test_mode();
      halted = 1'b1; test_en = 1'b1;
      wr(2'd0, 32'h0000_ABCD);
      test_en = 1'b0;
      rd_chk("R8 decrement", 2'd0, 32'd4);
   endtask

   task automatic t_bytes();
      halted = 1'b1;
      wr(2'd1, 32'd200);
      wr(2'd2, 32'h0000_2000);
      wr(2'd3, 32'h0000_0FFE);
      rd_chk("R10 readback", 2'd3, 32'h0000_FFFE);
      halted = 1'b0; bus_grant = 1'b1; xfer_strobe = 1'b1;
      tick(3);
      xfer_strobe = 1'b0;
      chk("R11 empty", {31'd0, buf_empty}, 32'd1);
      chk("R11 addr frozen", mem_addr, 32'h0000_2002);
      end_grant();
      halted = 1'b1;
      rd_chk("R10 wrapped", 2'd3, 32'h0000_F000);
   endtask

   initial begin
      #1;
      tick(2);
      rst_n = 1'b1;
      tick();
      t_reset();
      t_access();
      t_timer();
      t_notimer();
      t_burst();
      t_idle();
      t_test_mode();
      t_bytes();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #400000;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule